// File: doc/BRIEF.md
# Stuck Two-Wire Bus Detector and Recovery Sequencer

This block watches the filtered data and clock levels of the card-side segment of a buffered two-wire bus. If either line stays low longer than a timeout, it reports a fault. When automatic disconnection is allowed by a strap input, it asks the connection controller to isolate the segment. It then clocks the segment's SCL line to walk a confused slave off the bus, and finishes with a STOP condition.

All durations come from a system clock frequency parameter: the stuck timeout, the recovery clock half-period and the STOP hold time. The recovery clock is open-drain. The block pulls SCL low for one half-period, then releases it and waits until the line actually reads high before it times the high half. A slave that stretches the clock is therefore honoured. Dropping the enable input clears everything, and raising it re-arms detection from zero.

Top module: `stuck_bus_recovery`

## Requirements
- R1: SDA read low on STUCK_CYC consecutive clock edges asserts `fault_n` low on the last of those edges. A low lasting STUCK_CYC-1 edges leaves `fault_n` high.
- R2: SCL is timed by its own counter, and a stuck SCL alone asserts `fault_n` with the same timing as R1.
- R3: With `disc_en` high, `disc_req` rises together with the fault, and `scl_drv` (1 = pull SCL low) rises on the same edge. Each pulse holds `scl_drv` for HALF_CYC cycles. With no clock stretching, consecutive pulse starts are 2*HALF_CYC+1 cycles apart.
- R4: After releasing SCL, the sequencer starts the high half only once SCL reads high. A slave holding SCL low for S extra cycles lengthens that pulse period by exactly S cycles.
- R5: If SDA reads high at the end of a pulse's high half, clocking stops and `fault_n` returns high. The number of pulses equals the number after which the slave let SDA go.
- R6: The STOP drives `sda_drv` (1 = pull SDA low) for STOP_CYC cycles while SCL is released. After a successful recovery, `disc_req` falls on the edge where `sda_drv` falls.
- R7: Recovery issues at most MAX_PULSES (16) pulses. If SDA is still low after the last pulse, the STOP is still generated, while `fault_n` stays low and `disc_req` stays high. Both are released once SDA and SCL both read high.
- R8: With `disc_en` low, a stuck line still asserts `fault_n`, but `disc_req`, `scl_drv` and `sda_drv` stay low. The fault is held until `enable` is lowered.
- R9: `enable` low clears `fault_n` to high and clears `disc_req`, `scl_drv` and `sda_drv` on the next edge, and zeroes both timers. After `enable` returns high, a full STUCK_CYC of low is needed again.
- R10: After reset `fault_n` is high and `disc_req`, `scl_drv`, `sda_drv` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Filtered SDA level of the card segment |
| scl_in | input | 1 | Filtered SCL level of the card segment |
| disc_en | input | 1 | Strap: 1 allows disconnection and recovery |
| enable | input | 1 | Block enable; low clears fault and timers |
| fault_n | output | 1 | Stuck-bus fault, active low |
| disc_req | output | 1 | Request to the connection controller to isolate the segment |
| scl_drv | output | 1 | 1 = pull card-side SCL low |
| sda_drv | output | 1 | 1 = pull card-side SDA low |

## Verification
The hardest state to reach from the ports is the exhausted-recovery path. There, all sixteen pulses go by with SDA still low, the STOP is issued, and the block sits in its retry wait with the fault still reported. The bench models the open-drain wires as the AND of the block's releases and a slave model that never lets go. It then releases the slave in the cycle after the STOP ends, which lands inside the retry window. Clock stretching is reached the same way: the slave model grabs SCL in the very cycle the block releases it, so the wait state is held for a known count.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    ST_MON,    // watching both lines
    ST_RPT,    // fault reported, no recovery allowed
    ST_CLO,    // driving SCL low
    ST_CWAIT,  // SCL released, waiting for it to read high
    ST_CHI,    // timing the SCL high half
    ST_SLO,    // holding SDA low ahead of the STOP
    ST_RETRY   // recovery failed, fault kept, timers re-armed
  } sbr_state_t;
endpackage

// File: rtl/sbr_low_timer.sv
module sbr_low_timer #(
  parameter int LIMIT = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic line,
  output logic hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CW-1:0] cnt;

  assign hit = run && !line && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || line) cnt <= '0;
    else if (!hit)           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sbr_seq.sv
module sbr_seq
  import sbr_pkg::*;
#(
  parameter int HALF_CYC   = 10,
  parameter int STOP_CYC   = 20,
  parameter int MAX_PULSES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic disc_en,
  input  logic sda_in,
  input  logic scl_in,
  input  logic hit,
  output logic timer_run,
  output logic fault_n,
  output logic disc_req,
  output logic scl_drv,
  output logic sda_drv
);
  localparam int LONGEST = (HALF_CYC > STOP_CYC) ? HALF_CYC : STOP_CYC;
  localparam int PW = $clog2(LONGEST + 1);
  localparam int NW = $clog2(MAX_PULSES + 1);

  sbr_state_t    state, nxt;
  logic [PW-1:0] tcnt, tcnt_n;
  logic [NW-1:0] pcnt, pcnt_n;
  logic          fault_q, fault_d, disc_q, disc_d, freed_q, freed_d;
  logic          half_done, stop_done;

  assign half_done = (tcnt == PW'(HALF_CYC - 1));
  assign stop_done = (tcnt == PW'(STOP_CYC - 1));
  assign timer_run = enable && (state == ST_MON || state == ST_RETRY);

  always_comb begin
    nxt     = state;
    tcnt_n  = tcnt;
    pcnt_n  = pcnt;
    fault_d = fault_q;
    disc_d  = disc_q;
    freed_d = freed_q;
    if (!enable) begin
      nxt     = ST_MON;
      tcnt_n  = '0;
      pcnt_n  = '0;
      fault_d = 1'b0;
      disc_d  = 1'b0;
      freed_d = 1'b0;
    end else begin
      case (state)
        ST_MON: if (hit) begin
          fault_d = 1'b1;
          if (disc_en) begin
            disc_d = 1'b1;
            nxt    = ST_CLO;
            tcnt_n = '0;
            pcnt_n = '0;
          end else begin
            nxt = ST_RPT;
          end
        end
        ST_RPT: nxt = ST_RPT;
        ST_CLO: begin
          tcnt_n = tcnt + 1'b1;
          if (half_done) begin
            nxt    = ST_CWAIT;
            tcnt_n = '0;
          end
        end
        ST_CWAIT: if (scl_in) begin
          nxt    = ST_CHI;
          tcnt_n = '0;
        end
        ST_CHI: begin
          tcnt_n = tcnt + 1'b1;
          if (half_done) begin
            tcnt_n = '0;
            pcnt_n = pcnt + 1'b1;
            if (sda_in) begin
              freed_d = 1'b1;
              fault_d = 1'b0;
              nxt     = ST_SLO;
            end else if (pcnt_n == NW'(MAX_PULSES)) begin
              freed_d = 1'b0;
              nxt     = ST_SLO;
            end else begin
              nxt = ST_CLO;
            end
          end
        end
        ST_SLO: begin
          tcnt_n = tcnt + 1'b1;
          if (stop_done) begin
            tcnt_n = '0;
            if (freed_q) begin
              disc_d = 1'b0;
              nxt    = ST_MON;
            end else begin
              nxt = ST_RETRY;
            end
          end
        end
        ST_RETRY: begin
          if (sda_in && scl_in) begin
            fault_d = 1'b0;
            disc_d  = 1'b0;
            nxt     = ST_MON;
          end else if (hit) begin
            nxt    = ST_CLO;
            tcnt_n = '0;
            pcnt_n = '0;
          end
        end
        default: nxt = ST_MON;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_MON;
      tcnt    <= '0;
      pcnt    <= '0;
      fault_q <= 1'b0;
      disc_q  <= 1'b0;
      freed_q <= 1'b0;
      scl_drv <= 1'b0;
      sda_drv <= 1'b0;
    end else begin
      state   <= nxt;
      tcnt    <= tcnt_n;
      pcnt    <= pcnt_n;
      fault_q <= fault_d;
      disc_q  <= disc_d;
      freed_q <= freed_d;
      scl_drv <= (nxt == ST_CLO);
      sda_drv <= (nxt == ST_SLO);
    end
  end

  assign fault_n  = ~fault_q;
  assign disc_req = disc_q;
endmodule

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int STUCK_US   = 30_000,
  parameter int TOGGLE_HZ  = 8_500,
  parameter int STOP_US    = 125,
  parameter int MAX_PULSES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_in,
  input  logic scl_in,
  input  logic disc_en,
  input  logic enable,
  output logic fault_n,
  output logic disc_req,
  output logic scl_drv,
  output logic sda_drv
);
  localparam longint STUCK_L = (longint'(CLK_HZ) * longint'(STUCK_US)) / 64'd1_000_000;
  localparam longint STOP_L  = (longint'(CLK_HZ) * longint'(STOP_US)) / 64'd1_000_000;
  localparam int     HALF_R  = CLK_HZ / (2 * TOGGLE_HZ);
  localparam int STUCK_CYC = (STUCK_L < 2) ? 2 : int'(STUCK_L);
  localparam int STOP_CYC  = (STOP_L < 1) ? 1 : int'(STOP_L);
  localparam int HALF_CYC  = (HALF_R < 1) ? 1 : HALF_R;

  logic [1:0] lvl, line_hit;
  logic       timer_run;

  assign lvl = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    sbr_low_timer #(.LIMIT(STUCK_CYC)) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .run  (timer_run),
      .line (lvl[g]),
      .hit  (line_hit[g])
    );
  end

  sbr_seq #(
    .HALF_CYC   (HALF_CYC),
    .STOP_CYC   (STOP_CYC),
    .MAX_PULSES (MAX_PULSES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .disc_en   (disc_en),
    .sda_in    (sda_in),
    .scl_in    (scl_in),
    .hit       (|line_hit),
    .timer_run (timer_run),
    .fault_n   (fault_n),
    .disc_req  (disc_req),
    .scl_drv   (scl_drv),
    .sda_drv   (sda_drv)
  );
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker (
  input logic clk,
  input logic rst,
  input logic sda_in,
  input logic scl_in,
  input logic disc_en,
  input logic enable,
  input logic fault_n,
  input logic disc_req,
  input logic scl_drv,
  input logic sda_drv
);
  AST_DRIVE_ONLY_DISC: assert property (@(posedge clk) disable iff (rst)
    (scl_drv || sda_drv) |-> disc_req);                                   // R8
  AST_ONE_LINE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !(scl_drv && sda_drv));                                               // R6
  AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drv) |-> scl_in);                                           // R6
  AST_DISC_WITH_FAULT: assert property (@(posedge clk) disable iff (rst)
    $rose(disc_req) |-> (!fault_n && disc_en));                           // R3
  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (fault_n && !disc_req && !scl_drv && !sda_drv));          // R9
endmodule

bind stuck_bus_recovery sbr_checker u_chk (.*);

// File: tb/stuck_bus_recovery_bench.sv
module stuck_bus_recovery_bench;
  localparam int LIMIT = 200;   // 1 MHz assumed clock, 200 us timeout
  localparam int H     = 10;    // 50 kHz toggle -> 10-cycle half period
  localparam int SC    = 20;    // 20 us STOP hold
  localparam int MAXP  = 16;
  localparam int S     = 15;

  logic clk = 0, rst = 1, disc_en = 1, enable = 1;
  logic slave_sda = 0, slave_scl = 0, auto_rel = 0, mon_clr = 1;
  int   release_after = 0;
  logic fault_n, disc_req, scl_drv, sda_drv, sda_in, scl_in;
  int   errors = 0, checks = 0, cyc = 0, rises = 0;
  int   rise_t[32];
  int   fall_t[32];
  int   falls = 0;
  logic prev_scl = 0;

  always #5 clk = ~clk;

  assign sda_in = ~(sda_drv | (slave_sda & ~auto_rel));
  assign scl_in = ~(scl_drv | slave_scl);

  stuck_bus_recovery #(.CLK_HZ(1_000_000), .STUCK_US(200), .TOGGLE_HZ(50_000),
                       .STOP_US(20), .MAX_PULSES(MAXP)) u_stuck_bus_recovery (
    .clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in), .disc_en(disc_en),
    .enable(enable), .fault_n(fault_n), .disc_req(disc_req),
    .scl_drv(scl_drv), .sda_drv(sda_drv));

  // monitor samples 2 ns after the edge, away from both edges
  always @(posedge clk) begin
    #2;
    cyc++;
    if (mon_clr) begin
      rises = 0; falls = 0; prev_scl = 0; auto_rel = 0;
    end else begin
      if (scl_drv && !prev_scl) begin
        if (rises < 32) rise_t[rises] = cyc;
        rises++;
        if (release_after != 0 && rises == release_after) auto_rel = 1;
      end
      if (!scl_drv && prev_scl) begin
        if (falls < 32) fall_t[falls] = cyc;
        falls++;
      end
      prev_scl = scl_drv;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic de);
    @(negedge clk);
    rst = 1; mon_clr = 1; slave_sda = 0; slave_scl = 0; enable = 1;
    disc_en = de; release_after = 0;
    tick(3);
    rst = 0; mon_clr = 0;
    tick(1);
  endtask

  task automatic wait_sda_drv(input logic v);
    for (int i = 0; i < 3000 && sda_drv != v; i++) tick(1);
  endtask

  task automatic t_reset();
    do_reset(1);
    chk("R10 fault_n", fault_n, 1);
    chk("R10 disc_req", disc_req, 0);
    chk("R10 drives", {scl_drv, sda_drv}, 0);
  endtask

  task automatic t_short();
    do_reset(1);
    slave_sda = 1; tick(LIMIT - 1); slave_sda = 0;
    tick(20);
    chk("R1 short low no fault", fault_n, 1);
  endtask

  task automatic t_sda_report();
    do_reset(0);
    slave_sda = 1;
    tick(LIMIT - 1);
    chk("R1 before timeout", fault_n, 1);
    tick(1);
    chk("R1 at timeout", fault_n, 0);
    tick(60);
    chk("R8 no disconnect", disc_req, 0);
    chk("R8 no clocking", rises, 0);
    chk("R8 no sda drive", sda_drv, 0);
    chk("R8 fault held", fault_n, 0);
    enable = 0; tick(2);
    chk("R8 fault cleared by enable", fault_n, 1);
    enable = 1; slave_sda = 0;
  endtask

  task automatic t_scl_report();
    do_reset(0);
    slave_scl = 1;
    tick(LIMIT - 1);
    chk("R2 before timeout", fault_n, 1);
    tick(1);
    chk("R2 at timeout", fault_n, 0);
    slave_scl = 0;
  endtask

  task automatic t_early();
    int w;
    do_reset(1);
    release_after = 5;
    slave_sda = 1;
    tick(LIMIT);
    chk("R3 fault", fault_n, 0);
    chk("R3 disc_req with fault", disc_req, 1);
    chk("R3 first pulse", scl_drv, 1);
    wait_sda_drv(1);
    chk("R5 fault released at stop", fault_n, 1);
    chk("R5 pulses before release", rises, 5);
    chk("R3 pulse period", rise_t[1] - rise_t[0], 2 * H + 1);
    chk("R3 low half width", fall_t[0] - rise_t[0], H);
    chk("R6 scl released in stop", scl_drv, 0);
    w = 0;
    while (sda_drv && w < 1000) begin tick(1); w++; end
    chk("R6 stop hold", w, SC);
    chk("R6 disc_req dropped", disc_req, 0);
    slave_sda = 0;
  endtask

  task automatic t_stretch();
    do_reset(1);
    release_after = 3;
    slave_sda = 1;
    for (int i = 0; i < 1000 && !(rises == 1 && !scl_drv); i++) tick(1);
    slave_scl = 1;
    tick(S);
    chk("R4 no drive while stretched", scl_drv, 0);
    chk("R4 no pulse counted", rises, 1);
    slave_scl = 0;
    wait_sda_drv(1);
    chk("R4 stretched period", rise_t[1] - rise_t[0], 2 * H + 1 + S);
    chk("R4 pulses", rises, 3);
    wait_sda_drv(0);
    slave_sda = 0;
  endtask

  task automatic t_exhaust();
    do_reset(1);
    slave_sda = 1;
    tick(LIMIT);
    wait_sda_drv(1);
    chk("R7 pulse cap", rises, MAXP);
    chk("R7 fault kept in stop", fault_n, 0);
    wait_sda_drv(0);
    chk("R7 fault kept after stop", fault_n, 0);
    chk("R7 disc kept after stop", disc_req, 1);
    slave_sda = 0;
    tick(3);
    chk("R7 fault released on idle", fault_n, 1);
    chk("R7 disc released on idle", disc_req, 0);
  endtask

  task automatic t_enable();
    do_reset(1);
    slave_sda = 1;
    tick(LIMIT);
    for (int i = 0; i < 1000 && rises < 3; i++) tick(1);
    enable = 0;
    tick(2);
    chk("R9 fault cleared", fault_n, 1);
    chk("R9 disc cleared", disc_req, 0);
    chk("R9 drives cleared", {scl_drv, sda_drv}, 0);
    enable = 1;
    tick(LIMIT - 1);
    chk("R9 full timeout again", fault_n, 1);
    tick(1);
    chk("R9 fault after full timeout", fault_n, 0);
    slave_sda = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_short();
    t_sda_report();
    t_scl_report();
    t_early();
    t_stretch();
    t_exhaust();
    t_enable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule